// File: doc/BRIEF.md
# Selectable-Rate Decimating Averaging Filter

This block sits behind a sigma-delta capacitance converter. It turns a stream of 16-bit samples into one averaged 16-bit word for each conversion stage. A conversion sequencer pulses `stage_start` at the beginning of each stage. At that moment the block takes the 2-bit rate code as the decimation rate for the stage, clears any partial sum, and begins to add up incoming samples. The input side is a single `smp_valid` strobe with its data word.

Because of the filter structure, the number of samples averaged is three times the decimation rate. Rate code 0 averages 768 samples, code 1 averages 384, and codes 2 and 3 both average 192. At a 250 kHz sample rate this gives one result per 3.072 ms, 1.536 ms or 0.768 ms. A longer average gives a quieter result at a lower output rate.

When the final sample of a stage has been added, the block divides the total by the sample count, rounds to nearest, and presents the word with a one-cycle `avg_valid` pulse. It then stays idle until the next `stage_start`.

Top module: `dcf_avg_filter`

## Requirements
- R1: After synchronous reset, `avg_valid` is 0, `avg_data` is 0, and the filter is idle.
- R2: With rate code 2'b00 latched, exactly 768 accepted samples produce one result.
- R3: With rate code 2'b01 latched, exactly 384 accepted samples produce one result.
- R4: Rate codes 2'b10 and 2'b11 both select 192 samples per result.
- R5: The result equals floor((S + N/2) / N), where S is the sum of the stage's N samples, so halves round upward.
- R6: 768 samples of 16'hFFFF give 16'hFFFF, with no wrap in the running sum.
- R7: `avg_valid` is high for exactly one cycle: the cycle after the clock edge that accepts the final sample. `avg_data` holds its value until the next result.
- R8: A `stage_start` pulse discards any partial sum. A sample valid in the same cycle as `stage_start` counts as the first sample of the new stage.
- R9: The rate code is sampled only on `stage_start`. Changing `rate_sel` during a stage does not alter that stage's sample count.
- R10: Once a stage's result is issued, samples are ignored until the next `stage_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_start | input | 1 | Starts a new stage, latches the rate code, clears the sum |
| rate_sel | input | 2 | Decimation rate code (00:256, 01:128, 10/11:64) |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Unsigned converter sample |
| avg_valid | output | 1 | One-cycle pulse marking a new averaged word |
| avg_data | output | 16 | Rounded average of the stage's samples |

## Verification
Constant inputs at each rate code show whether the sample count is right: a result that arrives one sample early or late is caught by where the pulse lands. A ramp and an alternating pattern make the sum depend on every sample position, so a dropped or repeated sample is exposed. Exact half-way sums (96 ones in 192) and just-below-half sums (95 ones) separate round-to-nearest from truncation. Restarts in mid-stage, a sample that coincides with the start, a rate change in mid-stage, and samples arriving while idle each give a different wrong value if a stale sum or a wrong count leaks through. All-ones data at the longest rate probes the width of the sum.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int SMP_W_DEF    = 16;
    localparam int BASE_DEC_DEF = 256;
    localparam int TAP_MULT     = 3;

    typedef enum logic [1:0] {
        RATE_FULL  = 2'b00,
        RATE_HALF  = 2'b01,
        RATE_QTR_A = 2'b10,
        RATE_QTR_B = 2'b11
    } rate_code_e;

    // Right-shift applied to the base decimation rate for a given code.
    function automatic logic [1:0] rate_shift(input logic [1:0] code);
        case (rate_code_e'(code))
            RATE_FULL: return 2'd0;
            RATE_HALF: return 2'd1;
            default:   return 2'd2;
        endcase
    endfunction

    // ceil(2^s / 3): reciprocal used for the exact divide by three.
    function automatic longint unsigned recip3(input int s);
        return ((64'd1 << s) + 64'd2) / 64'd3;
    endfunction

endpackage

// File: rtl/dcf_rate_latch.sv
module dcf_rate_latch #(
    parameter int BASE_DEC = dcf_pkg::BASE_DEC_DEF,
    parameter int CNT_W    = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stage_start,
    input  logic [1:0]       rate_sel,
    output logic [1:0]       shift_k,
    output logic [CNT_W-1:0] target_n
);

    logic [1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= 2'd0;
        end else if (stage_start) begin
            shift_q <= dcf_pkg::rate_shift(rate_sel);
        end
    end

    assign shift_k  = shift_q;
    assign target_n = CNT_W'(dcf_pkg::TAP_MULT * (BASE_DEC >> shift_q));

    // R9: the stage length only moves on a stage start
    a_r9_rate_held: assert property (@(posedge clk) disable iff (rst)
        !stage_start |=> $stable(target_n));

endmodule

// File: rtl/dcf_accum.sv
module dcf_accum #(
    parameter int SMP_W = dcf_pkg::SMP_W_DEF,
    parameter int CNT_W = 10,
    parameter int ACC_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stage_start,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [CNT_W-1:0] target_n,
    output logic             fin,
    output logic [ACC_W-1:0] final_sum
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_q, st_d;
    logic       last_smp;

    assign last_smp  = (st_q.cnt == target_n - CNT_W'(1));
    assign fin       = st_q.busy && smp_valid && !stage_start && last_smp;
    assign final_sum = st_q.acc + ACC_W'(smp_data);

    always_comb begin
        st_d = st_q;
        if (stage_start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = smp_valid ? CNT_W'(1) : '0;
            st_d.acc  = smp_valid ? ACC_W'(smp_data) : '0;
        end else if (st_q.busy && smp_valid) begin
            if (last_smp) begin
                st_d = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                st_d.acc = final_sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2: the sample count never reaches the stage length while busy
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.busy |-> (st_q.cnt < target_n));

    // R6: the sum never exceeds count times full scale
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        st_q.busy |-> (64'(st_q.acc) <= 64'(st_q.cnt) * ((64'd1 << SMP_W) - 64'd1)));

    // R10: an idle filter holds no partial sum into the next cycle
    a_r10_idle_stays: assert property (@(posedge clk) disable iff (rst)
        (!st_q.busy && !stage_start) |=> !st_q.busy);

endmodule

// File: rtl/dcf_round_div.sv
module dcf_round_div #(
    parameter int SMP_W    = dcf_pkg::SMP_W_DEF,
    parameter int BASE_DEC = dcf_pkg::BASE_DEC_DEF,
    parameter int CNT_W    = 10,
    parameter int ACC_W    = 26
) (
    input  logic [ACC_W-1:0] sum_in,
    input  logic [1:0]       shift_k,
    input  logic [CNT_W-1:0] count_n,
    input  logic             chk_en,
    output logic [SMP_W-1:0] avg_out
);

    localparam int LOG_B  = $clog2(BASE_DEC);
    localparam int SUM_W  = ACC_W + 1;
    localparam int MIN_SH = LOG_B - 2;
    localparam int Y_W    = SUM_W - MIN_SH;
    localparam int RS     = Y_W + 2;
    localparam int P_W    = Y_W + RS;
    localparam logic [RS-1:0] RECIP = RS'(dcf_pkg::recip3(RS));

    logic [SUM_W-1:0] biased;
    logic [Y_W-1:0]   shifted [3];
    logic [Y_W-1:0]   y_sel;
    logic [P_W-1:0]   prod;

    assign biased = {1'b0, sum_in} + SUM_W'(count_n >> 1);

    // One power-of-two stage per rate; divide by 2^(LOG_B-k) first.
    for (genvar g = 0; g < 3; g++) begin : g_shift
        assign shifted[g] = Y_W'(biased >> (LOG_B - g));
    end

    always_comb begin
        case (shift_k)
            2'd0:    y_sel = shifted[0];
            2'd1:    y_sel = shifted[1];
            default: y_sel = shifted[2];
        endcase
    end

    // Exact floor(y/3) through reciprocal multiply.
    assign prod    = P_W'(y_sel) * P_W'(RECIP);
    assign avg_out = SMP_W'(prod >> RS);

    // R5: quotient brackets the biased sum
    always_comb begin
        if (chk_en) begin
            a_r5_round_nearest: assert (
                (64'(avg_out) * 64'(count_n) <= 64'(biased)) &&
                (64'(biased) < (64'(avg_out) + 64'd1) * 64'(count_n)));
        end
    end

endmodule

// File: rtl/dcf_avg_filter.sv
module dcf_avg_filter #(
    parameter int SMP_W    = dcf_pkg::SMP_W_DEF,
    parameter int BASE_DEC = dcf_pkg::BASE_DEC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stage_start,
    input  logic [1:0]       rate_sel,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic             avg_valid,
    output logic [SMP_W-1:0] avg_data
);

    localparam int MAX_N = dcf_pkg::TAP_MULT * BASE_DEC;
    localparam int CNT_W = $clog2(MAX_N + 1);
    localparam int ACC_W = SMP_W + $clog2(MAX_N);

    logic [1:0]       shift_k;
    logic [CNT_W-1:0] target_n;
    logic             fin;
    logic [ACC_W-1:0] final_sum;
    logic [SMP_W-1:0] quot;
    logic             vld_q;
    logic [SMP_W-1:0] res_q;

    dcf_rate_latch #(.BASE_DEC(BASE_DEC), .CNT_W(CNT_W)) u_rate (
        .clk(clk), .rst(rst), .stage_start(stage_start), .rate_sel(rate_sel),
        .shift_k(shift_k), .target_n(target_n)
    );

    dcf_accum #(.SMP_W(SMP_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .stage_start(stage_start), .smp_valid(smp_valid),
        .smp_data(smp_data), .target_n(target_n), .fin(fin), .final_sum(final_sum)
    );

    dcf_round_div #(.SMP_W(SMP_W), .BASE_DEC(BASE_DEC), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_div (
        .sum_in(final_sum), .shift_k(shift_k), .count_n(target_n),
        .chk_en(fin), .avg_out(quot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= fin;
            if (fin) res_q <= quot;
        end
    end

    assign avg_valid = vld_q;
    assign avg_data  = res_q;

    // R7: single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        avg_valid |=> !avg_valid);

    // R7: a result follows an accepted sample
    a_r7_after_sample: assert property (@(posedge clk) disable iff (rst)
        avg_valid |-> $past(smp_valid));

    // R8: a stage start never completes a result
    a_r8_start_no_result: assert property (@(posedge clk) disable iff (rst)
        stage_start |=> !avg_valid);

    // R7: the output word only moves together with a pulse
    a_r7_data_hold: assert property (@(posedge clk) disable iff (rst)
        !avg_valid |-> $stable(avg_data));

endmodule

// File: tb/tb_dcf_avg_filter.sv
module tb_dcf_avg_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stage_start = 1'b0;
    logic [1:0]  rate_sel = 2'b00;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        avg_valid;
    logic [15:0] avg_data;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] smp [768];

    int          pulses;
    logic [15:0] last_res;
    int          pulse_idx;

    always #10 clk = ~clk;

    dcf_avg_filter dut (
        .clk(clk), .rst(rst), .stage_start(stage_start), .rate_sel(rate_sel),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .avg_valid(avg_valid), .avg_data(avg_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint expect_avg(input int first, input int n);
        longint s = 0;
        for (int i = 0; i < n; i++) s += longint'(smp[first + i]);
        return (s + longint'(n / 2)) / longint'(n);
    endfunction

    task automatic start_stage(input logic [1:0] code);
        @(negedge clk);
        stage_start = 1'b1; rate_sel = code; smp_valid = 1'b0;
        @(negedge clk);
        stage_start = 1'b0;
    endtask

    // Sends smp[first .. first+cnt-1], one strobe every two cycles.
    task automatic feed(input int first, input int cnt);
        pulses = 0; pulse_idx = -1;
        for (int j = 0; j < cnt; j++) begin
            @(negedge clk);
            if (avg_valid) begin pulses++; last_res = avg_data; pulse_idx = first + j - 1; end
            smp_valid = 1'b1; smp_data = smp[first + j];
            @(negedge clk);
            smp_valid = 1'b0;
            if (avg_valid) begin pulses++; last_res = avg_data; pulse_idx = first + j; end
        end
    endtask

    task automatic expect_one(input string req, input int n, input longint expv);
        check(pulses == 1, req, pulses, 1);
        check(pulse_idx == n - 1, req, pulse_idx, n - 1);
        check(last_res == 16'(expv), req, last_res, expv);
        @(negedge clk);
        check(avg_valid == 1'b0, "R7", avg_valid, 0);
    endtask

    task automatic t_reset;
        check(avg_valid == 1'b0, "R1", avg_valid, 0);
        check(avg_data == 16'd0, "R1", avg_data, 0);
    endtask

    task automatic t_rate_full;
        for (int i = 0; i < 768; i++) smp[i] = 16'(1234 + (i % 7));
        start_stage(2'b00);
        feed(0, 768);
        expect_one("R2", 768, expect_avg(0, 768));
    endtask

    task automatic t_rate_half;
        for (int i = 0; i < 384; i++) smp[i] = 16'((i * 97) % 65536);
        start_stage(2'b01);
        feed(0, 384);
        expect_one("R3", 384, expect_avg(0, 384));
    endtask

    task automatic t_rate_qtr(input logic [1:0] code);
        for (int i = 0; i < 192; i++) smp[i] = (i % 2 == 0) ? 16'd40000 : 16'(i * 11);
        start_stage(code);
        feed(0, 192);
        expect_one("R4", 192, expect_avg(0, 192));
    endtask

    task automatic t_rounding;
        for (int i = 0; i < 192; i++) smp[i] = (i < 96) ? 16'd1 : 16'd0;
        start_stage(2'b10);
        feed(0, 192);
        expect_one("R5", 192, 1);
        for (int i = 0; i < 192; i++) smp[i] = (i < 95) ? 16'd1 : 16'd0;
        start_stage(2'b11);
        feed(0, 192);
        expect_one("R5", 192, 0);
    endtask

    task automatic t_full_scale;
        for (int i = 0; i < 768; i++) smp[i] = 16'hFFFF;
        start_stage(2'b00);
        feed(0, 768);
        expect_one("R6", 768, 65535);
    endtask

    task automatic t_hold;
        logic [15:0] held;
        held = avg_data;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(avg_valid == 1'b0 && avg_data == held, "R7", avg_data, held);
        end
    endtask

    task automatic t_restart;
        for (int i = 0; i < 192; i++) smp[i] = 16'd60000;
        start_stage(2'b10);
        feed(0, 100);
        check(pulses == 0, "R8", pulses, 0);
        for (int i = 0; i < 192; i++) smp[i] = 16'(i * 5);
        // start with a coincident first sample
        @(negedge clk);
        stage_start = 1'b1; rate_sel = 2'b10; smp_valid = 1'b1; smp_data = smp[0];
        @(negedge clk);
        stage_start = 1'b0; smp_valid = 1'b0;
        feed(1, 191);
        expect_one("R8", 192, expect_avg(0, 192));
    endtask

    task automatic t_rate_change;
        for (int i = 0; i < 192; i++) smp[i] = 16'(300 + i);
        start_stage(2'b10);
        feed(0, 100);
        rate_sel = 2'b00;
        feed(100, 92);
        check(pulses == 1 && pulse_idx == 191, "R9", pulse_idx, 191);
        check(last_res == 16'(expect_avg(0, 192)), "R9", last_res, expect_avg(0, 192));
    endtask

    task automatic t_idle_ignore;
        for (int i = 0; i < 50; i++) smp[i] = 16'hFFFF;
        feed(0, 50);
        check(pulses == 0, "R10", pulses, 0);
        for (int i = 0; i < 192; i++) smp[i] = 16'd0;
        start_stage(2'b11);
        feed(0, 192);
        expect_one("R10", 192, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rate_full();
        t_rate_half();
        t_rate_qtr(2'b10);
        t_rate_qtr(2'b11);
        t_rounding();
        t_full_scale();
        t_hold();
        t_restart();
        t_rate_change();
        t_idle_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule